// File: doc/BRIEF.md
# Byte-Programmed Interval Timer with Square-Wave Output

This block is a 16-bit down-counting interval timer for a peripheral controller. A processor programs it one byte at a time through a small register port with four indices: two bytes of the live counter and two bytes of a reload latch. Writing the high counter byte starts a count. The counter then steps down once per prescaled tick. An internal prescaler turns a system clock-enable into one tick for every `DIV` enabled cycles, ten by default.

A 2-bit mode input comes from the enclosing controller's auxiliary control register. It selects between two behaviours. In one-shot mode the timer raises its timeout flag once and then keeps counting through the wrap. In free-running mode it reloads from the latch at each timeout, raises the flag each time and toggles a square-wave pin. The enclosing controller places the timeout flag at bit 6 of its interrupt flag register.

Top module: `itmr_top`

## Requirements
- R1: After reset the timeout flag is 0, `out_pin` is 1, and reads of all four indices return 0.
- R2: The counter decrements once for every `DIV` cycles in which `clk_en` is 1. A tick is the enabled cycle that completes a group of `DIV`.
- R3: Index encoding: 0 = counter low, 1 = counter high, 2 = latch low, 3 = latch high. A write to index 0 or 2 updates the latch low byte. A write to index 3 updates the latch high byte. Reads of indices 2 and 3 return the latch bytes.
- R4: A write to index 1 does four things: it stores the byte into the latch high byte, loads the counter with {written byte, latch low byte}, clears the flag and starts the timer. A start outranks a tick in the same cycle.
- R5: When `mode` is 00, a tick at count 0 sets the flag only on the first pass after a start. The counter wraps to 0xFFFF and keeps counting.
- R6: When `mode` is 11, a tick at count 0 reloads the counter from the full latch and sets the flag, on every pass.
- R7: When `mode` is 11, `out_pin` goes low at a start and toggles at every timeout. In every other mode, `out_pin` is held at 1.
- R8: A read of index 0 clears the flag. Reads of the other indices leave it unchanged. A timeout in the same cycle as the read wins, and the flag is set.
- R9: Reads return the live counter bytes (indices 0 and 1) or latch bytes on `rdata` one cycle after the read. `rdata` holds its value in cycles without a read.
- R10: Modes 01 and 10 behave exactly as mode 00: a single timeout flag per start, and `out_pin` held at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | System clock-enable fed to the prescaler |
| mode | input | 2 | Timer mode (11 free-running, others one-shot) |
| sel | input | 1 | Register access select |
| wr | input | 1 | 1 = write, 0 = read |
| idx | input | 2 | Register index |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Registered read byte |
| tmo_flag | output | 1 | Timeout interrupt flag |
| out_pin | output | 1 | Square-wave / one-shot output |

## Verification
The bench targets the corners of the timer's behaviour:
- A restart on the same cycle as a tick. A design that let the tick win would load a stale or decremented count.
- A flag-clearing read on the same cycle as a timeout. A design that cleared there would lose an interrupt.
- The wrap in one-shot mode. A design that re-armed at the wrap would fire a second interrupt.
- A latch of zero in free-running mode. A design that mishandled the reload would stop toggling or run at the wrong period.
- The unused modes 01 and 10. A design that treated them as free-running would toggle the pin.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;

  typedef enum logic [1:0] {
    IX_CNT_LO = 2'd0,
    IX_CNT_HI = 2'd1,
    IX_LAT_LO = 2'd2,
    IX_LAT_HI = 2'd3
  } reg_ix_e;

  localparam logic [1:0] MODE_FREE = 2'b11;
endpackage

// File: rtl/itmr_prescale.sv
module itmr_prescale #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic clk_en,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst)
      phase <= '0;
    else if (clk_en)
      phase <= (phase == LAST) ? '0 : phase + 1'b1;
  end

  assign tick = clk_en && (phase == LAST);
endmodule

// File: rtl/itmr_core.sv
module itmr_core
  import itmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              free_run,
  input  logic              start,
  input  logic              lat_lo_we,
  input  logic              lat_hi_we,
  input  logic              rd_clr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  lat,
  output logic              armed,
  output logic              flag,
  output logic              pin_q,
  output logic              zero_hit
);
  assign zero_hit = tick && (cnt == '0) && !start;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat <= '0;
    end else begin
      if (lat_lo_we) lat[BYTE_W-1:0]     <= wdata;
      if (lat_hi_we) lat[CNT_W-1:BYTE_W] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      armed <= 1'b0;
      flag  <= 1'b0;
      pin_q <= 1'b1;
    end else if (start) begin
      cnt   <= {wdata, lat[BYTE_W-1:0]};
      armed <= 1'b1;
      flag  <= 1'b0;
      pin_q <= 1'b0;
    end else begin
      if (zero_hit) begin
        armed <= 1'b0;
        if (free_run) begin
          cnt   <= lat;
          flag  <= 1'b1;
          pin_q <= ~pin_q;
        end else begin
          cnt <= cnt - 1'b1;
          if (armed) begin
            flag  <= 1'b1;
            pin_q <= 1'b1;
          end else if (rd_clr) begin
            flag <= 1'b0;
          end
        end
      end else begin
        if (tick) cnt <= cnt - 1'b1;
        if (rd_clr) flag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/itmr_top.sv
module itmr_top
  import itmr_pkg::*;
#(
  parameter int DIV = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  logic [1:0]        mode,
  input  logic              sel,
  input  logic              wr,
  input  logic [1:0]        idx,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              tmo_flag,
  output logic              out_pin
);
  logic             tick;
  logic             start, lat_lo_we, lat_hi_we, rd_clr, free_run;
  logic [CNT_W-1:0] cnt, lat;
  logic             armed, pin_q, zero_hit;
  reg_ix_e          ix;

  assign ix        = reg_ix_e'(idx);
  assign free_run  = (mode == MODE_FREE);
  assign start     = sel && wr && (ix == IX_CNT_HI);
  assign lat_lo_we = sel && wr && (ix == IX_CNT_LO || ix == IX_LAT_LO);
  assign lat_hi_we = sel && wr && (ix == IX_CNT_HI || ix == IX_LAT_HI);
  assign rd_clr    = sel && !wr && (ix == IX_CNT_LO);

  itmr_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst(rst), .clk_en(clk_en), .tick(tick)
  );

  itmr_core u_core (
    .clk(clk), .rst(rst), .tick(tick), .free_run(free_run), .start(start),
    .lat_lo_we(lat_lo_we), .lat_hi_we(lat_hi_we), .rd_clr(rd_clr),
    .wdata(wdata), .cnt(cnt), .lat(lat), .armed(armed), .flag(tmo_flag),
    .pin_q(pin_q), .zero_hit(zero_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (sel && !wr) begin
      unique case (ix)
        IX_CNT_LO: rdata <= cnt[BYTE_W-1:0];
        IX_CNT_HI: rdata <= cnt[CNT_W-1:BYTE_W];
        IX_LAT_LO: rdata <= lat[BYTE_W-1:0];
        IX_LAT_HI: rdata <= lat[CNT_W-1:BYTE_W];
      endcase
    end
  end

  assign out_pin = free_run ? pin_q : 1'b1;
endmodule

// File: rtl/itmr_checker.sv
module itmr_checker
  import itmr_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             start,
  input logic             free_run,
  input logic             rd_clr,
  input logic             zero_hit,
  input logic             armed,
  input logic             pin_q,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] lat,
  input logic             tmo_flag,
  input logic             out_pin
);
  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    (!tick && !start) |=> $stable(cnt));

  a_r4_start_clears_flag: assert property (@(posedge clk) disable iff (rst)
    start |=> !tmo_flag);

  a_r6_reload_from_latch: assert property (@(posedge clk) disable iff (rst)
    (zero_hit && free_run) |=> (cnt == $past(lat)) && tmo_flag);

  a_r5_flag_needs_arm: assert property (@(posedge clk) disable iff (rst)
    $rose(tmo_flag) |-> ($past(armed) || $past(free_run)));

  a_r7_toggle_on_timeout: assert property (@(posedge clk) disable iff (rst)
    (zero_hit && free_run) |=> (pin_q != $past(pin_q)));

  a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && !start && !zero_hit) |=> !tmo_flag);

  a_r7_idle_high: assert property (@(posedge clk) disable iff (rst)
    !free_run |-> out_pin);
endmodule

bind itmr_top itmr_checker u_chk (
  .clk(clk), .rst(rst), .tick(tick), .start(start), .free_run(free_run),
  .rd_clr(rd_clr), .zero_hit(zero_hit), .armed(armed), .pin_q(pin_q),
  .cnt(cnt), .lat(lat), .tmo_flag(tmo_flag), .out_pin(out_pin)
);

// File: tb/tb_itmr_top.sv
module tb_itmr_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clk_en = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       sel = 1'b0, wr = 1'b0;
  logic [1:0] idx = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       tmo_flag, out_pin;

  int checks = 0, fails = 0;

  // reference state
  int        m_pre;
  logic [15:0] m_cnt, m_lat;
  logic      m_arm, m_flag, m_pin;
  logic [7:0] m_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  itmr_top #(.DIV(DIV)) dut (
    .clk(clk), .rst(rst), .clk_en(clk_en), .mode(mode), .sel(sel), .wr(wr),
    .idx(idx), .wdata(wdata), .rdata(rdata), .tmo_flag(tmo_flag), .out_pin(out_pin)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] read_val(input logic [1:0] i);
    case (i)
      2'd0: return m_cnt[7:0];
      2'd1: return m_cnt[15:8];
      2'd2: return m_lat[7:0];
      default: return m_lat[15:8];
    endcase
  endfunction

  function automatic logic exp_pin();
    return (mode == 2'b11) ? m_pin : 1'b1;
  endfunction

  task automatic model_reset();
    m_pre = 0; m_cnt = '0; m_lat = '0; m_arm = 0; m_flag = 0; m_pin = 1; m_rd = '0;
  endtask

  // advance reference by one clock, from inputs as currently driven
  task automatic model_step();
    bit tk, st, zh, fr, rc;
    logic [15:0] n_cnt = m_cnt, n_lat = m_lat;
    logic n_arm = m_arm, n_flag = m_flag, n_pin = m_pin;
    tk = clk_en && (m_pre == DIV - 1);
    if (clk_en) m_pre = (m_pre == DIV - 1) ? 0 : m_pre + 1;
    st = sel && wr && idx == 2'd1;
    rc = sel && !wr && idx == 2'd0;
    fr = (mode == 2'b11);
    zh = tk && m_cnt == 0 && !st;
    if (sel && !wr) m_rd = read_val(idx);
    if (sel && wr && (idx == 2'd0 || idx == 2'd2)) n_lat[7:0] = wdata;
    if (sel && wr && (idx == 2'd1 || idx == 2'd3)) n_lat[15:8] = wdata;
    if (st) begin
      n_cnt = {wdata, m_lat[7:0]}; n_arm = 1; n_flag = 0; n_pin = 0;
    end else begin
      if (tk) n_cnt = m_cnt - 1'b1;
      if (rc) n_flag = 0;
      if (zh) begin
        n_arm = 0;
        if (fr) begin n_cnt = m_lat; n_flag = 1; n_pin = ~m_pin; end
        else if (m_arm) begin n_flag = 1; n_pin = 1; end
      end
    end
    m_cnt = n_cnt; m_lat = n_lat; m_arm = n_arm; m_flag = n_flag; m_pin = n_pin;
  endtask

  task automatic step();
    model_step();
    @(posedge clk);
    @(negedge clk);
    check(tmo_flag == m_flag, "R8 flag", tmo_flag, m_flag);
    check(out_pin == exp_pin(), "R7 pin", out_pin, exp_pin());
    check(rdata == m_rd, "R9 rdata", rdata, m_rd);
    sel = 0; wr = 0;
  endtask

  task automatic acc(input bit w, input logic [1:0] i, input logic [7:0] d);
    sel = 1; wr = w; idx = i; wdata = d;
    step();
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int toggles;
    logic last;
    void'($urandom(32'h1d2c3b4a));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset state
    check(tmo_flag == 0, "R1 flag", tmo_flag, 0);
    check(out_pin == 1, "R1 pin", out_pin, 1);
    for (int i = 0; i < 4; i++) begin
      acc(0, 2'(i), 8'h00);
      check(rdata == 8'h00, "R1 read", rdata, 0);
    end
    clk_en = 1;
    // R3: latch writes through index 0, 2 and 3
    acc(1, 2'd0, 8'h5a); acc(0, 2'd2, 0);
    check(rdata == 8'h5a, "R3 latch low via 0", rdata, 8'h5a);
    acc(1, 2'd2, 8'h03); acc(1, 2'd3, 8'h77); acc(0, 2'd3, 0);
    check(rdata == 8'h77, "R3 latch high", rdata, 8'h77);
    // R4: start loads {data, latch low}
    acc(1, 2'd1, 8'h00); acc(0, 2'd3, 0);
    check(rdata == 8'h00, "R4 latch high takes start byte", rdata, 0);
    check(tmo_flag == 0, "R4 flag cleared", tmo_flag, 0);
    // R2/R5: count of 3 expires within 4 ticks
    idle(4 * DIV + 2);
    check(tmo_flag == 1, "R5 one-shot timeout", tmo_flag, 1);
    check(out_pin == 1, "R10 pin idle in one-shot", out_pin, 1);
    acc(0, 2'd1, 0);
    check(rdata == 8'hff, "R5 wrap to FFFF", rdata, 8'hff);
    acc(0, 2'd0, 0);
    idle(3);
    check(tmo_flag == 0, "R8 read clears", tmo_flag, 0);
    idle(20 * DIV);
    check(tmo_flag == 0, "R5 no second flag", tmo_flag, 0);
    // R6/R7: free-running, latch 2 -> period 3 ticks
    mode = 2'b11;
    acc(1, 2'd2, 8'h02); acc(1, 2'd1, 8'h00);
    check(out_pin == 0, "R7 start drives low", out_pin, 0);
    toggles = 0; last = out_pin;
    for (int k = 0; k < 30 * DIV; k++) begin
      step();
      if (out_pin != last) toggles++;
      last = out_pin;
    end
    check(toggles >= 9 && toggles <= 10, "R6 periodic toggles", toggles, 10);
    check(tmo_flag == 1, "R6 flag set", tmo_flag, 1);
    // R10: modes 01 and 10 behave as one-shot
    for (int mm = 1; mm <= 2; mm++) begin
      mode = 2'(mm);
      acc(1, 2'd2, 8'h01); acc(1, 2'd1, 8'h00);
      idle(3 * DIV + 2);
      check(tmo_flag == 1, "R10 timeout", tmo_flag, 1);
      check(out_pin == 1, "R10 pin held", out_pin, 1);
      acc(0, 2'd0, 0);
      idle(10 * DIV);
      check(tmo_flag == 0, "R10 single flag", tmo_flag, 0);
    end
    // random mix, compared every cycle with the reference
    for (int k = 0; k < 30000; k++) begin
      clk_en = ($urandom % 10) != 0;
      if ($urandom % 400 == 0) mode = 2'($urandom);
      if ($urandom % 6 == 0) begin
        logic [1:0] ri = 2'($urandom);
        logic [7:0] rd = 8'($urandom);
        if (ri[0] && ($urandom % 4 != 0)) rd = 8'h00;
        if (!ri[0]) rd = rd & 8'h0f;
        acc(1'($urandom), ri, rd);
      end else begin
        step();
      end
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule